// File: doc/BRIEF.md
# Two-Wire Serial Front End for a 1K x 8 Non-Volatile Memory

This block is the bus-facing controller of a byte-addressable 1024 x 8 non-volatile store. It watches an open-drain two-wire bus (a clock line and a data line, both sampled into the system clock domain through two flip-flops) and pulls the data line low through an output enable whenever it has to drive a zero. It frames the bus into start and stop conditions and 8-bit bytes. It decodes a control byte that carries a fixed 4-bit prefix, one chip-select bit compared against a strap pin, two upper address bits and a direction bit. It acknowledges each accepted byte and turns the traffic into single-cycle write and read requests on a memory-side port.

Writes carry a low address byte and then any number of data bytes. Each data byte becomes one write request, and the address advances only inside a 16-byte page. Reads stream bytes out from a 10-bit address counter for as long as the bus master keeps acknowledging. While the memory side reports an internal write cycle in progress, the block stays silent, so a master can poll for completion by repeating the control byte until it is acknowledged.

Top module: `twi_nvm_frontend`

## Requirements
- R1: A data-line fall while the clock line is high (START) restarts control-byte reception from any state and releases the data line. A data-line rise while the clock line is high (STOP) returns the block to idle.
- R2: A control byte whose bits 7:4 are 1010 and whose bit 3 equals `strap_sel` is acknowledged: the block holds the data line low for the whole ninth clock.
- R3: A control byte that fails either the prefix or the strap comparison gets no acknowledge. All later bytes are then ignored (no acknowledge, no request) until the next START.
- R4: In a write transfer, the byte after the control byte is acknowledged and becomes address bits 7:0. Control-byte bits 2:1 become address bits 9:8 in every transfer.
- R5: Each data byte of a write transfer is acknowledged and produces exactly one `mem_wr_en` pulse, with `mem_addr` set to the current address and `mem_wdata` set to the byte. Write and read requests never coincide.
- R6: After each written byte, address bits 3:0 increment modulo 16 and bits 9:4 stay unchanged.
- R7: In a read transfer (control bit 0 = 1), the byte at the current address is sent most significant bit first. The data line is only ever pulled low after a clock-line fall.
- R8: After a sent byte, the full 10-bit address increments with wrap. A master acknowledge (low in the ninth clock) starts the next byte. A master no-acknowledge makes the block release the line and stay silent until a START.
- R9: While `mem_busy` is high, the block never drives the data line, acknowledges nothing and issues no requests.
- R10: A START issued after the word address (a repeated START) followed by a read control byte reads from the address just set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_pull_low | output | 1 | 1 = pull the data line low |
| strap_sel | input | 1 | Hard-wired chip-select strap |
| mem_busy | input | 1 | Internal write cycle in progress |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd_en` |
| mem_wr_en | output | 1 | One-cycle write request |
| mem_rd_en | output | 1 | One-cycle read request |
| mem_addr | output | 10 | Request address |
| mem_wdata | output | 8 | Write data |

## Verification
The bench targets page wrap at the last byte of a 16-byte page. A design that carried into bit 4 would write to the next page. It also reads across the top of the address space, where a counter that wrapped only within a page, or that dropped the control-byte bank bits, would return the wrong byte. Control bytes failing only the strap bit, and failing only the prefix, are sent with trailing data to catch a decoder that acknowledges or writes on a partial match. A repeated START mid-transfer and a poll while busy expose a design that keeps its old state, or that acknowledges during the write cycle.

// File: rtl/twi_nvm_pkg.sv
package twi_nvm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK
  } bus_state_t;

  typedef enum logic [1:0] {
    K_CTRL, K_WADDR, K_WDATA
  } rx_kind_t;

  localparam logic [3:0] CTRL_PREFIX = 4'b1010;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '1;
        else if (s == 0) chain[s] <= raw_i;
        else chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_nvm_proto.sv
module twi_nvm_proto
  import twi_nvm_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              strap,
  input  logic              busy,
  input  logic [DATA_W-1:0] rdata,
  output logic              sda_oe,
  output logic              wr_en,
  output logic              rd_en,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int BANK_W = ADDR_W - DATA_W;

  bus_state_t        st;
  rx_kind_t          kind;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rx_sh, tx_sh;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        rd_wait;
  logic              is_read, m_ack;
  logic              ctrl_ok;

  assign ctrl_ok = (rx_sh[DATA_W-1 -: 4] == CTRL_PREFIX) && (rx_sh[DATA_W-5] == strap);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; kind <= K_CTRL; cnt <= '0;
      rx_sh <= '0; tx_sh <= '0; addr_q <= '0; rd_wait <= '0;
      is_read <= 1'b0; m_ack <= 1'b0; sda_oe <= 1'b0;
      wr_en <= 1'b0; rd_en <= 1'b0; addr_o <= '0; wdata_o <= '0;
    end else begin
      wr_en   <= 1'b0;
      rd_en   <= 1'b0;
      rd_wait <= {rd_wait[0], 1'b0};
      if (rd_wait[1]) tx_sh <= rdata;
      if (busy) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else if (start_evt) begin
        st <= ST_RX; kind <= K_CTRL; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_evt) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              rx_sh <= {rx_sh[DATA_W-2:0], sda_lvl};
              cnt   <= cnt + CNT_W'(1);
            end else if (scl_fall && cnt == CNT_W'(DATA_W)) begin
              cnt <= '0;
              case (kind)
                K_CTRL: begin
                  if (ctrl_ok) begin
                    addr_q[ADDR_W-1 -: BANK_W] <= rx_sh[BANK_W:1];
                    is_read <= rx_sh[0];
                    sda_oe  <= 1'b1;
                    st      <= ST_ACK;
                    if (rx_sh[0]) begin
                      rd_en   <= 1'b1;
                      addr_o  <= {rx_sh[BANK_W:1], addr_q[DATA_W-1:0]};
                      rd_wait <= {rd_wait[0], 1'b1};
                    end
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                K_WADDR: begin
                  addr_q[DATA_W-1:0] <= rx_sh;
                  sda_oe <= 1'b1;
                  st     <= ST_ACK;
                end
                default: begin
                  wr_en   <= 1'b1;
                  addr_o  <= addr_q;
                  wdata_o <= rx_sh;
                  addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + PAGE_W'(1);
                  sda_oe  <= 1'b1;
                  st      <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (kind == K_CTRL && is_read) begin
                st     <= ST_TX;
                sda_oe <= ~tx_sh[DATA_W-1];
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
                kind   <= (kind == K_CTRL) ? K_WADDR : K_WDATA;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + CNT_W'(1);
            end else if (scl_fall) begin
              if (cnt == CNT_W'(DATA_W)) begin
                sda_oe  <= 1'b0;
                st      <= ST_MACK;
                cnt     <= '0;
                addr_q  <= addr_q + ADDR_W'(1);
                addr_o  <= addr_q + ADDR_W'(1);
                rd_en   <= 1'b1;
                rd_wait <= {rd_wait[0], 1'b1};
              end else begin
                tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
                sda_oe <= ~tx_sh[DATA_W-2];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (m_ack) begin
                st     <= ST_TX;
                sda_oe <= ~tx_sh[DATA_W-1];
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7: the line is only ever pulled low while the clock line is low
  a_r7_drive_when_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl);

  // R9: a busy memory silences the bus side on the next cycle
  a_r9_busy_silent: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!sda_oe && !wr_en && !rd_en));

  // R5: one request kind at a time
  a_r5_req_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));

  // R1: a START releases the data line
  a_r1_start_releases: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> !sda_oe);

  // R6: consecutive writes stay in one page
  a_r6_page_kept: assert property (@(posedge clk) disable iff (rst || start_evt)
    (wr_en && st == ST_ACK) |-> (addr_o[ADDR_W-1:PAGE_W] == addr_q[ADDR_W-1:PAGE_W]));
endmodule

// File: rtl/twi_nvm_frontend.sv
module twi_nvm_frontend #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull_low,
  input  logic              strap_sel,
  input  logic              mem_busy,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_wr_en,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic [1:0] lines_s;
  logic scl_rise, scl_fall, start_evt, stop_evt;

  twi_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw_i({scl_in, sda_in}), .sync_o(lines_s)
  );

  twi_cond_detect u_cond (
    .clk(clk), .rst(rst), .scl_s(lines_s[1]), .sda_s(lines_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  twi_nvm_proto #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_proto (
    .clk(clk), .rst(rst), .scl_lvl(lines_s[1]), .sda_lvl(lines_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .strap(strap_sel), .busy(mem_busy), .rdata(mem_rdata),
    .sda_oe(sda_pull_low), .wr_en(mem_wr_en), .rd_en(mem_rd_en),
    .addr_o(mem_addr), .wdata_o(mem_wdata)
  );
endmodule

// File: tb/tb_twi_nvm_frontend.sv
`timescale 1ns/1ps
module tb_twi_nvm_frontend;
  localparam int HALF = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1;
  logic strap_sel = 1'b1, mem_busy = 1'b0;
  logic [7:0] mem_rdata;
  logic sda_pull_low, mem_wr_en, mem_rd_en;
  logic [9:0] mem_addr;
  logic [7:0] mem_wdata;
  wire sda_line = sda_m & ~sda_pull_low;

  int checks = 0, fails = 0;
  logic [17:0] exp_q[$];
  logic [7:0] store [1024];

  always #5 clk = ~clk;

  twi_nvm_frontend dut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
    .sda_pull_low(sda_pull_low), .strap_sel(strap_sel), .mem_busy(mem_busy),
    .mem_rdata(mem_rdata), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  initial for (int i = 0; i < 1024; i++) store[i] = 8'(i) ^ 8'h5A;

  always @(posedge clk) begin
    if (mem_wr_en) store[mem_addr] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= store[mem_addr];
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every write request must match the next expected item
  always @(negedge clk) begin
    if (!rst && mem_wr_en) begin
      if (exp_q.size() == 0) check(1'b0, "R3/R9 unexpected write", {mem_addr, mem_wdata}, 0);
      else begin
        logic [17:0] e;
        e = exp_q.pop_front();
        check({mem_addr, mem_wdata} == e, "R5/R6 write item", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(HALF); scl = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF); scl = 1'b0; tick(HALF / 2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HALF); scl = 1'b1; tick(HALF); sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(HALF / 2); scl = 1'b1; tick(HALF); scl = 1'b0; tick(HALF / 2);
    end
    sda_m = 1'b1; tick(HALF / 2); scl = 1'b1; tick(HALF / 2);
    acked = ~sda_line; tick(HALF / 2);
    scl = 1'b0; tick(HALF / 2);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(HALF / 2); scl = 1'b1; tick(HALF / 2);
      b[i] = sda_line; tick(HALF / 2); scl = 1'b0; tick(HALF / 2);
    end
    sda_m = ~give_ack; tick(HALF / 2); scl = 1'b1; tick(HALF); scl = 1'b0;
    sda_m = 1'b1; tick(HALF / 2);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] d;
    tick(5); rst = 1'b0; tick(5);
    check(!sda_pull_low && !mem_wr_en && !mem_rd_en, "R1 reset idle", sda_pull_low, 0);

    // byte write to 0x2F3: control 1010_1_10_0
    bus_start();
    send_byte(8'hAC, a); check(a, "R2 control ack", a, 1);
    send_byte(8'hF3, a); check(a, "R4 word address ack", a, 1);
    exp_q.push_back({10'h2F3, 8'h3C});
    send_byte(8'h3C, a); check(a, "R5 data ack", a, 1);
    bus_stop(); tick(4);
    check(exp_q.size() == 0, "R5 write issued", exp_q.size(), 0);

    // page write wrapping 0x1FE -> 0x1FF -> 0x1F0
    bus_start();
    send_byte(8'hAA, a); send_byte(8'hFE, a);
    exp_q.push_back({10'h1FE, 8'h11}); send_byte(8'h11, a);
    exp_q.push_back({10'h1FF, 8'h22}); send_byte(8'h22, a);
    exp_q.push_back({10'h1F0, 8'h33}); send_byte(8'h33, a);
    check(a, "R6 third page byte ack", a, 1);
    bus_stop(); tick(4);
    check(exp_q.size() == 0, "R6 page wrap writes", exp_q.size(), 0);

    // strap mismatch: bit3 = 0
    bus_start();
    send_byte(8'hA4, a); check(!a, "R3 strap mismatch nack", a, 0);
    send_byte(8'h55, a); check(!a, "R3 ignored after mismatch", a, 0);
    send_byte(8'h66, a);
    bus_stop();
    // prefix mismatch
    bus_start();
    send_byte(8'hBC, a); check(!a, "R3 prefix mismatch nack", a, 0);
    send_byte(8'h77, a); check(!a && !sda_pull_low, "R3 silent after prefix", a, 0);
    bus_stop(); tick(4);

    // repeated START random read at 0x2F3 then 0x2F4
    bus_start();
    send_byte(8'hAC, a); send_byte(8'hF3, a);
    bus_start();
    send_byte(8'hAD, a); check(a, "R10 read control ack", a, 1);
    recv_byte(1'b1, d); check(d == 8'h3C, "R10 R7 first read byte", d, 8'h3C);
    recv_byte(1'b0, d); check(d == (8'hF4 ^ 8'h5A), "R8 next address byte", d, 8'hF4 ^ 8'h5A);
    tick(HALF); check(!sda_pull_low, "R8 released after nack", sda_pull_low, 0);
    bus_stop();

    // read across the top of the space: 0x3FF then 0x000
    bus_start();
    send_byte(8'hAE, a); send_byte(8'hFF, a);
    bus_start(); send_byte(8'hAF, a);
    recv_byte(1'b1, d); check(d == (8'hFF ^ 8'h5A), "R7 read 0x3FF", d, 8'hFF ^ 8'h5A);
    recv_byte(1'b0, d); check(d == 8'h5A, "R8 10-bit wrap", d, 8'h5A);
    bus_stop();

    // current-address read: bank from control, low byte now 0x01
    bus_start(); send_byte(8'hAF, a);
    recv_byte(1'b0, d); check(d == 8'h5B, "R4 bank bits on read", d, 8'h5B);
    bus_stop();

    // START mid-transfer aborts and restarts control reception
    bus_start();
    send_byte(8'hAC, a); send_byte(8'h10, a);
    bus_start();
    send_byte(8'hA8, a); check(a, "R1 restart control ack", a, 1);
    send_byte(8'h40, a);
    exp_q.push_back({10'h040, 8'h99}); send_byte(8'h99, a);
    bus_stop(); tick(4);
    check(exp_q.size() == 0, "R1 write after restart", exp_q.size(), 0);

    // polling during an internal write cycle
    mem_busy = 1'b1;
    bus_start();
    send_byte(8'hAC, a); check(!a, "R9 busy nack", a, 0);
    send_byte(8'h01, a); send_byte(8'hEE, a);
    check(!a, "R9 data ignored while busy", a, 0);
    bus_stop();
    mem_busy = 1'b0; tick(4);
    bus_start();
    send_byte(8'hAC, a); check(a, "R9 ack once idle", a, 1);
    bus_stop(); tick(10);
    check(exp_q.size() == 0, "R9 no pending writes", exp_q.size(), 0);

    finish_run();
  end
endmodule